// File: doc/BRIEF.md
# Configurable Macrocell With Clock Select

This block is a single programmable logic cell that sits after a product-term sum. It picks a data source: either the allocator sum or a direct pad input, which turns the cell into a fast input register. It can invert that value with a programmable XOR. The result is stored in an element that the configuration makes a D flip-flop, a T flip-flop or a level-sensitive latch.

The clock of the storage element comes from an eight-way selector. The choices are four block clocks, a shared product-term clock, an individual product-term clock in true or complemented form, and a constant low that freezes the cell. Asynchronous reset, preset and power-up initialisation override the clock, and an optional product-term enable qualifies it.

Two outputs leave the cell. One goes toward output routing and can carry the stored bit or bypass it with the combinational value. The other carries the stored bit back into global routing. All configuration inputs are static settings.

Top module: `mc_macrocell`

## Requirements
- R1: When `cfg_inv_i` is 1, the value stored or bypassed is the complement of the selected source; when it is 0, the source passes unchanged.
- R2: With `cfg_mode_i` 0 (or 3), the element is a D flip-flop that loads the post-XOR value on a rising edge of the selected clock while the enable is active.
- R3: With `cfg_mode_i` 1, the element is a T flip-flop. It inverts its stored bit on a rising edge of the selected clock when the post-XOR value is 1 and the enable is active, and holds its bit when that value is 0.
- R4: `cfg_io_src_i` = 1 selects `io_in_i` as the data source; 0 selects `alloc_sum_i`.
- R5: Clock select codes: 0 to 3 pick `blk_clk_i[0]` to `blk_clk_i[3]`, 4 picks `shr_pt_clk_i`, 5 picks `pt_clk_i`, and 6 picks the inverse of `pt_clk_i`, so a code-6 flip-flop loads on a falling edge of `pt_clk_i`.
- R6: With `cfg_mode_i` 2, the element is a latch. It follows the post-XOR value while the selected clock is high and the enable is active, and holds its value while the clock is low.
- R7: When `cfg_ce_use_i` is 1, the element changes on a clock only if `pt_ce_i` is 1. When `cfg_ce_use_i` is 0, `pt_ce_i` is ignored.
- R8: Clock select code 7 is a constant low clock. With it, pulses on every clock input leave the stored bit unchanged.
- R9: `pwr_init_i` high forces the stored bit to `cfg_init_val_i` at once, and this overrides reset and preset.
- R10: `rst_i` high clears the stored bit and `pst_i` high sets it, both asynchronously. Reset wins when both are high, and no clock changes the bit while either is held.
- R11: `fb_o` always carries the stored bit. `route_o` carries the stored bit when `cfg_bypass_i` is 0, and the post-XOR combinational value when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| blk_clk_i | input | NUM_BLK_CLK | Block clocks, select codes 0 upward |
| shr_pt_clk_i | input | 1 | Shared product-term clock |
| pt_clk_i | input | 1 | Individual product-term clock |
| pt_ce_i | input | 1 | Product-term clock enable |
| alloc_sum_i | input | 1 | Sum from the allocator |
| io_in_i | input | 1 | Direct input from the pad path |
| rst_i | input | 1 | Asynchronous reset, active high |
| pst_i | input | 1 | Asynchronous preset, active high |
| pwr_init_i | input | 1 | Power-up initialisation, active high |
| cfg_mode_i | input | 2 | Storage mode: 0/3 D, 1 T, 2 latch |
| cfg_clk_sel_i | input | CLK_SEL_W | Clock source code |
| cfg_inv_i | input | 1 | Invert the data source |
| cfg_io_src_i | input | 1 | Use the pad input as the data source |
| cfg_ce_use_i | input | 1 | Qualify clocks with pt_ce_i |
| cfg_bypass_i | input | 1 | Send the combinational value to route_o |
| cfg_init_val_i | input | 1 | Value loaded at power-up initialisation |
| route_o | output | 1 | Output toward output routing |
| fb_o | output | 1 | Stored bit toward global routing |

## Verification
Combinational paths through the source select, XOR and bypass settle in the same time step as their inputs. The reset, preset and power-up controls act on the stored bit at the moment they change. A flip-flop result is due at the edge of the selected clock source. The bench sets data one bench cycle before it drives that edge, so sampled data never changes at the edge itself, and latch results are due while the selected clock is held high. Each expected item is queued when its stimulus has been applied, and the monitor pops and compares it on the next falling bench clock, half a period after the last input change.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [1:0] {
      MC_MODE_D     = 2'd0,
      MC_MODE_T     = 2'd1,
      MC_MODE_LATCH = 2'd2,
      MC_MODE_D_ALT = 2'd3
   } mc_mode_e;

   function automatic logic mc_is_toggle(input mc_mode_e m);
      return m == MC_MODE_T;
   endfunction

   function automatic logic mc_is_latch(input mc_mode_e m);
      return m == MC_MODE_LATCH;
   endfunction

endpackage

// File: rtl/mc_clk_mux.sv
module mc_clk_mux #(
   parameter int NUM_BLK_CLK = 4,
   parameter int CLK_SEL_W   = 3
) (
   input  logic [NUM_BLK_CLK-1:0] blk_clk_i,
   input  logic                   shr_pt_clk_i,
   input  logic                   pt_clk_i,
   input  logic [CLK_SEL_W-1:0]   sel_i,
   output logic                   clk_o
);
   localparam int NUM_SRC = 1 << CLK_SEL_W;
   localparam int IDX_SHR = NUM_BLK_CLK;
   localparam int IDX_PT  = NUM_BLK_CLK + 1;
   localparam int IDX_PTN = NUM_BLK_CLK + 2;

   logic [NUM_SRC-1:0] src;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         if (g < NUM_BLK_CLK) begin : g_blk
            assign src[g] = blk_clk_i[g];
         end else if (g == IDX_SHR) begin : g_shr
            assign src[g] = shr_pt_clk_i;
         end else if (g == IDX_PT) begin : g_pt
            assign src[g] = pt_clk_i;
         end else if (g == IDX_PTN) begin : g_ptn
            assign src[g] = ~pt_clk_i;
         end else begin : g_off
            assign src[g] = 1'b0;
         end
      end
   endgenerate

   assign clk_o = src[sel_i];
endmodule

// File: rtl/mc_data_path.sv
module mc_data_path (
   input  logic alloc_sum_i,
   input  logic io_in_i,
   input  logic use_io_i,
   input  logic inv_i,
   output logic d_o
);
   logic raw;

   assign raw = use_io_i ? io_in_i : alloc_sum_i;
   assign d_o = raw ^ inv_i;
endmodule

// File: rtl/mc_store.sv
module mc_store
   import mc_pkg::*;
#(
   parameter bit LATCH_EN = 1'b1
) (
   input  logic     clk_i,
   input  logic     init_i,
   input  logic     init_val_i,
   input  logic     rst_i,
   input  logic     pst_i,
   input  logic     ce_i,
   input  logic     d_i,
   input  mc_mode_e mode_i,
   output logic     q_o
);
   logic ff_q;
   logic ff_next;

   assign ff_next = mc_is_toggle(mode_i) ? (ff_q ^ d_i) : d_i;

   always_ff @(posedge clk_i or posedge init_i or posedge rst_i or posedge pst_i) begin
      if (init_i) begin
         ff_q <= init_val_i;
      end else if (rst_i) begin
         ff_q <= 1'b0;
      end else if (pst_i) begin
         ff_q <= 1'b1;
      end else if (ce_i) begin
         ff_q <= ff_next;
      end
   end

   generate
      if (LATCH_EN) begin : g_latch
         logic lat_q;

         always_latch begin
            if (init_i) begin
               lat_q = init_val_i;
            end else if (rst_i) begin
               lat_q = 1'b0;
            end else if (pst_i) begin
               lat_q = 1'b1;
            end else if (clk_i && ce_i) begin
               lat_q = d_i;
            end
         end

         assign q_o = mc_is_latch(mode_i) ? lat_q : ff_q;
      end else begin : g_no_latch
         assign q_o = ff_q;
      end
   endgenerate
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
   import mc_pkg::*;
#(
   parameter int NUM_BLK_CLK = 4,
   parameter int CLK_SEL_W   = 3,
   parameter bit LATCH_EN    = 1'b1
) (
   input  logic [NUM_BLK_CLK-1:0] blk_clk_i,
   input  logic                   shr_pt_clk_i,
   input  logic                   pt_clk_i,
   input  logic                   pt_ce_i,
   input  logic                   alloc_sum_i,
   input  logic                   io_in_i,
   input  logic                   rst_i,
   input  logic                   pst_i,
   input  logic                   pwr_init_i,
   input  logic [1:0]             cfg_mode_i,
   input  logic [CLK_SEL_W-1:0]   cfg_clk_sel_i,
   input  logic                   cfg_inv_i,
   input  logic                   cfg_io_src_i,
   input  logic                   cfg_ce_use_i,
   input  logic                   cfg_bypass_i,
   input  logic                   cfg_init_val_i,
   output logic                   route_o,
   output logic                   fb_o
);
   localparam int NUM_CODES  = 1 << CLK_SEL_W;
   localparam int USED_CODES = NUM_BLK_CLK + 3;

   generate
      if (NUM_BLK_CLK < 1) begin : g_chk_blk
         $error("mc_macrocell: NUM_BLK_CLK must be at least 1");
      end
      if (USED_CODES >= NUM_CODES) begin : g_chk_sel
         $error("mc_macrocell: CLK_SEL_W leaves no constant-low clock code");
      end
   endgenerate

   logic sel_clk;
   logic d_post;
   logic ce_eff;
   logic store_q;

   mc_clk_mux #(
      .NUM_BLK_CLK (NUM_BLK_CLK),
      .CLK_SEL_W   (CLK_SEL_W)
   ) u_clk_mux (
      .blk_clk_i    (blk_clk_i),
      .shr_pt_clk_i (shr_pt_clk_i),
      .pt_clk_i     (pt_clk_i),
      .sel_i        (cfg_clk_sel_i),
      .clk_o        (sel_clk)
   );

   mc_data_path u_data_path (
      .alloc_sum_i (alloc_sum_i),
      .io_in_i     (io_in_i),
      .use_io_i    (cfg_io_src_i),
      .inv_i       (cfg_inv_i),
      .d_o         (d_post)
   );

   assign ce_eff = cfg_ce_use_i ? pt_ce_i : 1'b1;

   mc_store #(
      .LATCH_EN (LATCH_EN)
   ) u_store (
      .clk_i      (sel_clk),
      .init_i     (pwr_init_i),
      .init_val_i (cfg_init_val_i),
      .rst_i      (rst_i),
      .pst_i      (pst_i),
      .ce_i       (ce_eff),
      .d_i        (d_post),
      .mode_i     (mc_mode_e'(cfg_mode_i)),
      .q_o        (store_q)
   );

   assign route_o = cfg_bypass_i ? d_post : store_q;
   assign fb_o    = store_q;
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk
   import mc_pkg::*;
(
   input logic       sel_clk,
   input logic       d_post,
   input logic       ce_eff,
   input logic       pwr_init_i,
   input logic       rst_i,
   input logic       pst_i,
   input logic [1:0] cfg_mode_i,
   input logic       cfg_bypass_i,
   input logic       route_o,
   input logic       fb_o
);
   logic edge_mode;
   assign edge_mode = (cfg_mode_i != MC_MODE_LATCH);

   // R11: without bypass both outputs carry the stored bit
   a_r11_route_matches_fb: assert property (@(posedge sel_clk) disable iff (pwr_init_i)
      !cfg_bypass_i |-> (route_o == fb_o));

   // R10: reset held means the bit is clear
   a_r10_rst_clears: assert property (@(posedge sel_clk) disable iff (pwr_init_i)
      rst_i |-> !fb_o);

   // R10: preset without reset means the bit is set
   a_r10_pst_sets: assert property (@(posedge sel_clk) disable iff (pwr_init_i)
      (pst_i && !rst_i) |-> fb_o);

   // R2: D mode loads the sampled data
   a_r2_d_load: assert property (@(posedge sel_clk) disable iff (pwr_init_i || rst_i || pst_i)
      ((cfg_mode_i == MC_MODE_D || cfg_mode_i == MC_MODE_D_ALT) && ce_eff)
      |=> (fb_o == $past(d_post)));

   // R3: T mode with a one toggles the bit
   a_r3_t_toggle: assert property (@(posedge sel_clk) disable iff (pwr_init_i || rst_i || pst_i)
      (cfg_mode_i == MC_MODE_T && ce_eff && d_post) |=> (fb_o != $past(fb_o)));

   // R7: an edge with the enable low leaves the bit alone
   a_r7_ce_hold: assert property (@(posedge sel_clk) disable iff (pwr_init_i || rst_i || pst_i)
      (edge_mode && !ce_eff) |=> $stable(fb_o));
endmodule

bind mc_macrocell mc_macrocell_chk i_chk (
   .sel_clk      (sel_clk),
   .d_post       (d_post),
   .ce_eff       (ce_eff),
   .pwr_init_i   (pwr_init_i),
   .rst_i        (rst_i),
   .pst_i        (pst_i),
   .cfg_mode_i   (cfg_mode_i),
   .cfg_bypass_i (cfg_bypass_i),
   .route_o      (route_o),
   .fb_o         (fb_o)
);

// File: tb/test_mc_macrocell.sv
module test_mc_macrocell;
   logic       clk = 1'b0;
   logic [3:0] blk_clk = 4'b0;
   logic       shr_clk = 1'b0;
   logic       pt_clk = 1'b0;
   logic       pt_ce = 1'b0;
   logic       alloc = 1'b0;
   logic       io_in = 1'b0;
   logic       rst = 1'b0;
   logic       pst = 1'b0;
   logic       pwr_init = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [2:0] csel = 3'd0;
   logic       inv = 1'b0;
   logic       io_src = 1'b0;
   logic       ce_use = 1'b0;
   logic       bypass = 1'b0;
   logic       init_val = 1'b1;
   logic       route;
   logic       fb;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   typedef struct {
      logic  exp_route;
      logic  exp_fb;
      string tag;
   } item_t;
   item_t sb[$];

   always #4 clk = ~clk;

   mc_macrocell i_mc_macrocell (
      .blk_clk_i      (blk_clk),
      .shr_pt_clk_i   (shr_clk),
      .pt_clk_i       (pt_clk),
      .pt_ce_i        (pt_ce),
      .alloc_sum_i    (alloc),
      .io_in_i        (io_in),
      .rst_i          (rst),
      .pst_i          (pst),
      .pwr_init_i     (pwr_init),
      .cfg_mode_i     (mode),
      .cfg_clk_sel_i  (csel),
      .cfg_inv_i      (inv),
      .cfg_io_src_i   (io_src),
      .cfg_ce_use_i   (ce_use),
      .cfg_bypass_i   (bypass),
      .cfg_init_val_i (init_val),
      .route_o        (route),
      .fb_o           (fb)
   );

   // monitor: one queued item per falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         n_run++;
         if (route !== it.exp_route || fb !== it.exp_fb) begin
            n_fail++;
            $display("FAIL %s: route=%b fb=%b expected route=%b fb=%b",
                     it.tag, route, fb, it.exp_route, it.exp_fb);
         end
      end
   end

   task automatic expect_out(input logic r, input logic f, input string tag);
      item_t it;
      it.exp_route = r;
      it.exp_fb    = f;
      it.tag       = tag;
      sb.push_back(it);
      @(posedge clk);
   endtask

   // which: 0..3 block clock, 4 shared, 5 product-term, 8 all of them
   task automatic pulse(input int which);
      @(posedge clk);
      if (which < 4)       blk_clk[which] = 1'b1;
      else if (which == 4) shr_clk = 1'b1;
      else if (which == 5) pt_clk = 1'b1;
      else begin blk_clk = 4'hF; shr_clk = 1'b1; pt_clk = 1'b1; end
      @(posedge clk);
      blk_clk = 4'h0;
      shr_clk = 1'b0;
      pt_clk  = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
   endtask

   initial begin
      step();
      // R9 power-up init
      pwr_init = 1'b1;
      expect_out(1'b1, 1'b1, "R9 init to one");
      pwr_init = 1'b0;
      expect_out(1'b1, 1'b1, "R9 value kept after init");
      init_val = 1'b0;
      pwr_init = 1'b1; rst = 1'b0; pst = 1'b1;
      expect_out(1'b0, 1'b0, "R9 init overrides preset");
      pwr_init = 1'b0; pst = 1'b0;
      step();

      // R2 D mode on block clock 0
      alloc = 1'b1; pulse(0);
      expect_out(1'b1, 1'b1, "R2 load one");
      alloc = 1'b0; pulse(0);
      expect_out(1'b0, 1'b0, "R2 load zero");

      // R5 clock select
      csel = 3'd2; alloc = 1'b1; pulse(0);
      expect_out(1'b0, 1'b0, "R5 unselected clock ignored");
      pulse(2);
      expect_out(1'b1, 1'b1, "R5 block clock 2");
      csel = 3'd4; alloc = 1'b0; pulse(4);
      expect_out(1'b0, 1'b0, "R5 shared clock");
      csel = 3'd5; alloc = 1'b1; pulse(5);
      expect_out(1'b1, 1'b1, "R5 true pt clock");
      pt_clk = 1'b1;
      step();
      csel = 3'd6; alloc = 1'b0;
      step();
      pt_clk = 1'b0;
      expect_out(1'b0, 1'b0, "R5 complemented pt clock loads on fall");
      alloc = 1'b1;
      step();
      pt_clk = 1'b1;
      expect_out(1'b0, 1'b0, "R5 complemented pt clock ignores rise");
      csel = 3'd0;
      step();
      pt_clk = 1'b0;
      step();

      // R8 constant-low clock code
      csel = 3'd7; alloc = 1'b1; pulse(8);
      expect_out(1'b0, 1'b0, "R8 code 7 holds");

      // R3 T mode
      csel = 3'd0; mode = 2'd1; alloc = 1'b1; pulse(0);
      expect_out(1'b1, 1'b1, "R3 toggle to one");
      pulse(0);
      expect_out(1'b0, 1'b0, "R3 toggle to zero");
      alloc = 1'b0; pulse(0);
      expect_out(1'b0, 1'b0, "R3 zero holds");

      // R7 clock enable
      mode = 2'd0; ce_use = 1'b1; pt_ce = 1'b0; alloc = 1'b1; pulse(0);
      expect_out(1'b0, 1'b0, "R7 enable low holds");
      pt_ce = 1'b1; pulse(0);
      expect_out(1'b1, 1'b1, "R7 enable high loads");
      ce_use = 1'b0; pt_ce = 1'b0; alloc = 1'b0; pulse(0);
      expect_out(1'b0, 1'b0, "R7 enable ignored when unused");

      // R1 inversion (mode 3 also acts as D)
      mode = 2'd3; inv = 1'b1; alloc = 1'b0; pulse(0);
      expect_out(1'b1, 1'b1, "R1 invert zero");
      alloc = 1'b1; pulse(0);
      expect_out(1'b0, 1'b0, "R1 invert one");
      inv = 1'b0; mode = 2'd0;

      // R4 pad source
      io_src = 1'b1; io_in = 1'b1; alloc = 1'b0; pulse(0);
      expect_out(1'b1, 1'b1, "R4 pad source one");
      io_in = 1'b0; alloc = 1'b1; pulse(0);
      expect_out(1'b0, 1'b0, "R4 pad source zero");
      io_src = 1'b0;

      // R10 reset and preset
      pst = 1'b1;
      expect_out(1'b1, 1'b1, "R10 preset sets");
      rst = 1'b1;
      expect_out(1'b0, 1'b0, "R10 reset wins over preset");
      pst = 1'b0;
      step();
      alloc = 1'b1; pulse(0);
      expect_out(1'b0, 1'b0, "R10 clock blocked during reset");
      rst = 1'b0;
      expect_out(1'b0, 1'b0, "R10 released reset keeps zero");

      // R6 latch
      mode = 2'd2; alloc = 1'b1;
      expect_out(1'b0, 1'b0, "R6 latch closed with clock low");
      blk_clk[0] = 1'b1;
      expect_out(1'b1, 1'b1, "R6 latch transparent");
      alloc = 1'b0;
      expect_out(1'b0, 1'b0, "R6 latch follows while high");
      blk_clk[0] = 1'b0;
      step();
      alloc = 1'b1;
      expect_out(1'b0, 1'b0, "R6 latch holds while low");

      // R11 bypass
      mode = 2'd0; rst = 1'b1;
      step();
      rst = 1'b0; bypass = 1'b1; alloc = 1'b1;
      expect_out(1'b1, 1'b0, "R11 bypass shows comb value");
      inv = 1'b1;
      expect_out(1'b0, 1'b0, "R11 bypass after inversion");
      inv = 1'b0; pulse(0);
      expect_out(1'b1, 1'b1, "R11 stored after clock");
      alloc = 1'b0;
      expect_out(1'b0, 1'b1, "R11 feedback keeps stored bit");

      step();
      step();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule